// File: doc/BRIEF.md
# Zero-Cross Synchronized Control Update

This block sits between a serial control receiver and the active control registers of a two-channel audio attenuation path. The receiver hands over a complete 44-bit control word together with a one-cycle commit strobe. The block then decides when that word becomes active. In zero-cross mode the copy waits for a zero-cross pulse from one chosen point in the signal chain, so that a gain step lands while the waveform crosses zero and causes no click. If that pulse does not arrive, a cycle-count timeout forces the copy. In immediate mode the copy happens on the commit itself.

The update mode and the tap select are taken from the incoming word at the commit edge, before the rest of the word is applied. One transfer can therefore switch on zero-cross mode, point the detector at the right stage and carry the payload that waits on it. Two channel bits in the word choose whether the left slice, the right slice or both are written. Each slice presents a fader code that is forced to full attenuation while the active-low mute input is low, or while the slice's main volume field holds the infinite-attenuation code.

Top module: `zc_update_ctrl`

## Requirements
- R1: After reset both active words equal the parameter RESET_WORD, both write strobes and the pending flag are 0, zc_mode_o is 0 and tap_sel_o is 0.
- R2: A commit whose mode field (bits 37:36) is anything other than 2'b00 writes the word on the commit clock edge; the write strobes are high in the following cycle, the pending flag is 0 and zero-cross pulses have no effect.
- R3: A commit with mode field 2'b00 sets the pending flag and writes nothing; the held word is written on the first later clock edge at which the selected zero-cross pulse is high.
- R4: The tap select is bits 39:38 read as an index with bit 38 as LSB (0 selector, 1 volume, 2 tone, 3 fader) and picks zc_pulse[index]; pulses on other taps do not release the word.
- R5: With no selected pulse, the held word is written on the TIMEOUT_CYC-th clock edge after the commit edge.
- R6: A commit that arrives while a word is pending replaces that word and restarts the timeout from the new commit edge.
- R7: zc_mode_o and tap_sel_o take the incoming word's mode and tap values at the commit edge, also while its payload is held.
- R8: Bit 32 enables the right slice and bit 33 the left slice; a word with both bits 0 writes neither slice.
- R9: While mute_n is 0 both fader outputs read 4'hF regardless of the active words.
- R10: The fader output of a slice is its word's bits 31:28 (bit 28 LSB), except that it reads 4'hF when the slice's bits 14:9 are all ones.
- R11: A commit and a selected zero-cross pulse in the same cycle: the commit wins, nothing is written and the new word is pending. A selected pulse and the timeout on the same edge produce a single write.
- R12: A slice's active word changes only on an edge that also raises its write strobe for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_word | input | 44 | Complete control word from the serial receiver |
| commit | input | 1 | One-cycle strobe: stage_word is complete |
| zc_pulse | input | 4 | Zero-cross pulses, one per tap point |
| mute_n | input | 1 | Active-low external mute |
| left_word_o | output | 44 | Active control word, left slice |
| left_we_o | output | 1 | Left slice was written on the last edge |
| right_word_o | output | 44 | Active control word, right slice |
| right_we_o | output | 1 | Right slice was written on the last edge |
| fader_left_o | output | 4 | Effective fader code, left slice |
| fader_right_o | output | 4 | Effective fader code, right slice |
| pending_o | output | 1 | A word is waiting for a zero-cross or timeout |
| zc_mode_o | output | 1 | Zero-cross mode active |
| tap_sel_o | output | 2 | Selected zero-cross tap |

## Verification
The release logic has two pairs of events that can meet on one edge: a fresh commit against a zero-cross pulse on the tap in use, and a selected pulse against timeout expiry. The bench drives a second commit in the very cycle the first word's tap pulses, then confirms that no slice was written, the new word is pending on its own tap, and a later pulse on the old tap does nothing. It also places a selected pulse exactly on the edge where the timeout runs out and checks for one write with a one-cycle strobe and a cleared pending flag.

// File: rtl/zcu_pkg.sv
package zcu_pkg;

    localparam int WORD_W      = 44;
    localparam int TAP_W       = 2;
    localparam int N_TAPS      = 1 << TAP_W;
    localparam int N_CHAN      = 2;
    localparam int CHAN_LSB    = 32;   // bit CHAN_LSB+c enables slice c (0 right, 1 left)
    localparam int MODE_LSB    = 36;   // two bits, 2'b00 selects zero-cross release
    localparam int TAP_LSB     = 38;   // two bits, index into the tap pulses
    localparam int VOL_INF_LSB = 9;
    localparam int VOL_INF_W   = 6;
    localparam int FADER_LSB   = 28;
    localparam int FADER_W     = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic             pending;
        logic             zc_mode;
        logic [TAP_W-1:0] tap;
        word_t            word;
    } ctl_t;

    typedef struct packed {
        logic  we;
        word_t word;
    } slice_t;

    function automatic logic wants_zc(input word_t w);
        return w[MODE_LSB +: 2] == 2'b00;
    endfunction

    function automatic logic [TAP_W-1:0] tap_of(input word_t w);
        return w[TAP_LSB +: TAP_W];
    endfunction

    function automatic logic vol_is_inf(input word_t w);
        return &w[VOL_INF_LSB +: VOL_INF_W];
    endfunction

    function automatic logic [FADER_W-1:0] fader_of(input word_t w);
        return w[FADER_LSB +: FADER_W];
    endfunction

endpackage

// File: rtl/zcu_timeout.sv
module zcu_timeout #(
    parameter int TIMEOUT_CYC = 480000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = CNT_INIT;
        end else if (run && tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    assign expire = run && !load && (tmr_q.cnt == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R6: every commit that waits restarts the full window
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> tmr_q.cnt == CNT_INIT);

    // R5: expiry is a single-cycle event
    p_expire_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

endmodule

// File: rtl/zcu_chan_reg.sv
module zcu_chan_reg
    import zcu_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_WORD = 44'h000_0000_7E00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  word_t              wdata,
    input  logic               mute_n,
    output word_t              word_o,
    output logic               we_o,
    output logic [FADER_W-1:0] fader_o
);
    slice_t slc_d, slc_q;

    always_comb begin
        slc_d    = slc_q;
        slc_d.we = wr;
        if (wr) slc_d.word = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slc_q.we   <= 1'b0;
            slc_q.word <= RESET_WORD;
        end else begin
            slc_q <= slc_d;
        end
    end

    assign word_o  = slc_q.word;
    assign we_o    = slc_q.we;
    assign fader_o = (!mute_n || vol_is_inf(slc_q.word)) ? '1 : fader_of(slc_q.word);

    // R12: the word never moves without the strobe
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !slc_q.we |-> $stable(slc_q.word));

    // R12: a write lands with its strobe one cycle later
    p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (slc_q.we && slc_q.word == $past(wdata)));

endmodule

// File: rtl/zc_update_ctrl.sv
module zc_update_ctrl
    import zcu_pkg::*;
#(
    parameter int                TIMEOUT_CYC = 480000,
    parameter logic [WORD_W-1:0] RESET_WORD  = 44'h000_0000_7E00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   stage_word,
    input  logic                commit,
    input  logic [N_TAPS-1:0]   zc_pulse,
    input  logic                mute_n,
    output logic [WORD_W-1:0]   left_word_o,
    output logic                left_we_o,
    output logic [WORD_W-1:0]   right_word_o,
    output logic                right_we_o,
    output logic [FADER_W-1:0]  fader_left_o,
    output logic [FADER_W-1:0]  fader_right_o,
    output logic                pending_o,
    output logic                zc_mode_o,
    output logic [TAP_W-1:0]    tap_sel_o
);
    ctl_t  ctl_d, ctl_q;
    logic  commit_zc;
    logic  zc_hit;
    logic  expire;
    logic  fire;
    word_t fire_word;

    word_t              word_a [N_CHAN];
    logic               we_a   [N_CHAN];
    logic [FADER_W-1:0] fad_a  [N_CHAN];

    assign commit_zc = commit && wants_zc(stage_word);
    assign zc_hit    = zc_pulse[ctl_q.tap];

    // Commit has priority over any release of the held word.
    always_comb begin
        ctl_d     = ctl_q;
        fire      = 1'b0;
        fire_word = ctl_q.word;
        if (commit) begin
            ctl_d.zc_mode = commit_zc;
            ctl_d.tap     = tap_of(stage_word);
            if (commit_zc) begin
                ctl_d.pending = 1'b1;
                ctl_d.word    = stage_word;
            end else begin
                ctl_d.pending = 1'b0;
                fire          = 1'b1;
                fire_word     = stage_word;
            end
        end else if (ctl_q.pending && (zc_hit || expire)) begin
            ctl_d.pending = 1'b0;
            fire          = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    zcu_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (commit_zc),
        .run    (ctl_q.pending),
        .expire (expire)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        zcu_chan_reg #(.RESET_WORD(RESET_WORD)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (fire && fire_word[CHAN_LSB + c]),
            .wdata   (fire_word),
            .mute_n  (mute_n),
            .word_o  (word_a[c]),
            .we_o    (we_a[c]),
            .fader_o (fad_a[c])
        );
    end

    assign right_word_o  = word_a[0];
    assign right_we_o    = we_a[0];
    assign fader_right_o = fad_a[0];
    assign left_word_o   = word_a[1];
    assign left_we_o     = we_a[1];
    assign fader_left_o  = fad_a[1];
    assign pending_o     = ctl_q.pending;
    assign zc_mode_o     = ctl_q.zc_mode;
    assign tap_sel_o     = ctl_q.tap;

    // R3: a waiting commit holds its payload back
    p_zc_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && stage_word[MODE_LSB +: 2] == 2'b00) |=>
            (pending_o && !left_we_o && !right_we_o));

    // R2: an immediate commit leaves nothing pending
    p_imm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && stage_word[MODE_LSB +: 2] != 2'b00) |=> !pending_o);

    // R7: tap select follows the committed word at once
    p_tap_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> tap_sel_o == $past(stage_word[TAP_LSB +: TAP_W]));

    // R8: no channel bit, no write
    p_chan_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && stage_word[MODE_LSB +: 2] != 2'b00 &&
         stage_word[CHAN_LSB +: 2] == 2'b00) |=> (!left_we_o && !right_we_o));

    // R9: external mute wins over both slices
    p_mute_fader_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |-> (fader_left_o == '1 && fader_right_o == '1));

endmodule

// File: tb/zc_update_ctrl_bench.sv
module zc_update_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 16;
    localparam logic [43:0] RST_W = 44'h000_0000_7E00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [43:0] stage_word = '0;
    logic        commit = 1'b0;
    logic [3:0]  zc_pulse = '0;
    logic        mute_n = 1'b1;
    logic [43:0] left_word_o, right_word_o;
    logic        left_we_o, right_we_o, pending_o, zc_mode_o;
    logic [3:0]  fader_left_o, fader_right_o;
    logic [1:0]  tap_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [43:0] exp_l = RST_W;
    logic [43:0] exp_r = RST_W;

    always #(CLK_PERIOD/2) clk = ~clk;

    zc_update_ctrl #(.TIMEOUT_CYC(TO), .RESET_WORD(RST_W)) u_zc_update_ctrl (
        .clk, .rst_n, .stage_word, .commit, .zc_pulse, .mute_n,
        .left_word_o, .left_we_o, .right_word_o, .right_we_o,
        .fader_left_o, .fader_right_o, .pending_o, .zc_mode_o, .tap_sel_o
    );

    typedef struct packed {
        logic       r;
        logic       l;
        logic       zc;
        logic [1:0] tap;
        logic [7:0] vol;
        logic [3:0] fad;
        logic [7:0] tag;
        logic [3:0] pulse;
        logic       wr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h10, 4'd3, 8'h01, 4'b0000, 1'b1},
        '{1'b0, 1'b1, 1'b1, 2'd1, 8'h05, 4'd2, 8'h02, 4'b0010, 1'b1},
        '{1'b1, 1'b0, 1'b1, 2'd2, 8'h08, 4'd6, 8'h03, 4'b0100, 1'b1},
        '{1'b1, 1'b1, 1'b1, 2'd3, 8'h22, 4'd9, 8'h04, 4'b1000, 1'b1},
        '{1'b1, 1'b1, 1'b1, 2'd0, 8'h30, 4'd1, 8'h05, 4'b0001, 1'b1},
        '{1'b1, 1'b1, 1'b1, 2'd1, 8'h31, 4'd4, 8'h06, 4'b0100, 1'b0},
        '{1'b1, 1'b0, 1'b0, 2'd2, 8'h12, 4'd7, 8'h07, 4'b1111, 1'b1},
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'h14, 4'd8, 8'h08, 4'b0000, 1'b1},
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h7E, 4'd2, 8'h09, 4'b0000, 1'b1}
    };

    function automatic logic [43:0] mk(input logic r, input logic l, input logic zc,
                                       input logic [1:0] tap, input logic [7:0] vol,
                                       input logic [3:0] fad, input logic [7:0] tag);
        logic [43:0] w;
        w        = '0;
        w[7:0]   = tag;
        w[15:8]  = vol;
        w[31:28] = fad;
        w[32]    = r;
        w[33]    = l;
        w[37:36] = zc ? 2'b00 : 2'b11;
        w[38]    = tap[0];
        w[39]    = tap[1];
        return w;
    endfunction

    function automatic logic [3:0] fad_exp(input logic [43:0] w);
        return (w[14:9] == 6'h3F) ? 4'hF : w[31:28];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic apply(input logic [43:0] w);
        if (w[32]) exp_r = w;
        if (w[33]) exp_l = w;
    endtask

    task automatic check_all(input string req, input logic wel, input logic wer);
        chk(left_word_o == exp_l, req, "left word", 64'(left_word_o), 64'(exp_l));
        chk(right_word_o == exp_r, req, "right word", 64'(right_word_o), 64'(exp_r));
        chk(left_we_o == wel, req, "left strobe", 64'(left_we_o), 64'(wel));
        chk(right_we_o == wer, req, "right strobe", 64'(right_we_o), 64'(wer));
        chk(fader_left_o == fad_exp(exp_l), req, "left fader", 64'(fader_left_o), 64'(fad_exp(exp_l)));
        chk(fader_right_o == fad_exp(exp_r), req, "right fader", 64'(fader_right_o), 64'(fad_exp(exp_r)));
    endtask

    task automatic do_commit(input logic [43:0] w);
        @(negedge clk);
        stage_word = w;
        commit     = 1'b1;
        @(negedge clk);
        commit     = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [43:0] w, wa, wb;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1", 1'b0, 1'b0);
        chk(pending_o == 1'b0, "R1", "pending", 64'(pending_o), 0);
        chk(zc_mode_o == 1'b0, "R1", "mode", 64'(zc_mode_o), 0);
        chk(tap_sel_o == 2'd0, "R1", "tap", 64'(tap_sel_o), 0);
        chk(fader_left_o == 4'hF, "R10", "reset fader inf", 64'(fader_left_o), 64'hF);

        // Table walk: R2, R3, R4, R7, R8
        for (int i = 0; i < NV; i++) begin
            w = mk(TBL[i].r, TBL[i].l, TBL[i].zc, TBL[i].tap, TBL[i].vol, TBL[i].fad, TBL[i].tag);
            do_commit(w);
            chk(pending_o == TBL[i].zc, TBL[i].zc ? "R3" : "R2", "pending after commit",
                64'(pending_o), 64'(TBL[i].zc));
            chk(tap_sel_o == TBL[i].tap, "R7", "tap after commit", 64'(tap_sel_o), 64'(TBL[i].tap));
            chk(zc_mode_o == TBL[i].zc, "R7", "mode after commit", 64'(zc_mode_o), 64'(TBL[i].zc));
            if (!TBL[i].zc) begin
                apply(w);
                check_all((w[33:32] == 2'b00) ? "R8" : "R2", w[33], w[32]);
            end else begin
                check_all("R3", 1'b0, 1'b0);
            end
            if (TBL[i].pulse != 4'b0000) begin
                zc_pulse = TBL[i].pulse;
                @(negedge clk);
                zc_pulse = '0;
                if (TBL[i].zc && TBL[i].wr) begin
                    apply(w);
                    check_all("R3", w[33], w[32]);
                    chk(pending_o == 1'b0, "R3", "pending after release", 64'(pending_o), 0);
                end else begin
                    check_all(TBL[i].zc ? "R4" : "R2", 1'b0, 1'b0);
                    chk(pending_o == TBL[i].zc, TBL[i].zc ? "R4" : "R2", "pending after pulse",
                        64'(pending_o), 64'(TBL[i].zc));
                end
            end
        end
        chk(fader_left_o == 4'hF && fader_right_o == 4'hF, "R10", "volume inf forces fader",
            64'({fader_left_o, fader_right_o}), 64'hFF);

        // R9: external mute
        @(negedge clk);
        w = mk(1'b1, 1'b1, 1'b0, 2'd0, 8'h04, 4'd5, 8'h0A);
        do_commit(w);
        apply(w);
        @(negedge clk);
        mute_n = 1'b0;
        #1;
        chk(fader_left_o == 4'hF && fader_right_o == 4'hF, "R9", "mute forces fader",
            64'({fader_left_o, fader_right_o}), 64'hFF);
        mute_n = 1'b1;
        #1;
        chk(fader_left_o == 4'd5, "R10", "fader field after unmute", 64'(fader_left_o), 64'd5);

        // R5: timeout release
        w = mk(1'b1, 1'b1, 1'b1, 2'd0, 8'h20, 4'd6, 8'hA1);
        do_commit(w);
        repeat (TO - 1) @(negedge clk);
        check_all("R5", 1'b0, 1'b0);
        chk(pending_o == 1'b1, "R5", "pending before timeout", 64'(pending_o), 1);
        @(negedge clk);
        apply(w);
        check_all("R5", 1'b1, 1'b1);
        chk(pending_o == 1'b0, "R5", "pending after timeout", 64'(pending_o), 0);

        // R6: replacement restarts the timer
        wa = mk(1'b1, 1'b1, 1'b1, 2'd0, 8'h21, 4'd3, 8'hB1);
        wb = mk(1'b1, 1'b1, 1'b1, 2'd0, 8'h22, 4'd4, 8'hB2);
        do_commit(wa);
        repeat (10) @(negedge clk);
        do_commit(wb);
        repeat (TO - 1) @(negedge clk);
        check_all("R6", 1'b0, 1'b0);
        chk(pending_o == 1'b1, "R6", "still pending past first window", 64'(pending_o), 1);
        @(negedge clk);
        apply(wb);
        check_all("R6", 1'b1, 1'b1);

        // R11: commit in the same cycle as the selected pulse
        wa = mk(1'b1, 1'b1, 1'b1, 2'd1, 8'h23, 4'd7, 8'hC1);
        wb = mk(1'b1, 1'b1, 1'b1, 2'd2, 8'h24, 4'd8, 8'hC2);
        do_commit(wa);
        stage_word = wb;
        commit     = 1'b1;
        zc_pulse   = 4'b0010;
        @(negedge clk);
        commit     = 1'b0;
        zc_pulse   = '0;
        check_all("R11", 1'b0, 1'b0);
        chk(pending_o == 1'b1, "R11", "new word pending", 64'(pending_o), 1);
        chk(tap_sel_o == 2'd2, "R11", "new tap", 64'(tap_sel_o), 2);
        zc_pulse = 4'b0010;
        @(negedge clk);
        zc_pulse = '0;
        check_all("R4", 1'b0, 1'b0);
        zc_pulse = 4'b0100;
        @(negedge clk);
        zc_pulse = '0;
        apply(wb);
        check_all("R11", 1'b1, 1'b1);

        // R11: pulse and timeout on the same edge, R12 single strobe
        w = mk(1'b1, 1'b0, 1'b1, 2'd3, 8'h25, 4'd9, 8'hD1);
        do_commit(w);
        repeat (TO - 1) @(negedge clk);
        zc_pulse = 4'b1000;
        @(negedge clk);
        zc_pulse = '0;
        apply(w);
        check_all("R11", 1'b0, 1'b1);
        @(negedge clk);
        check_all("R12", 1'b0, 1'b0);
        chk(pending_o == 1'b0, "R11", "pending after joint release", 64'(pending_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule